// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog counter configured over a simple write/read register port with four word-spaced locations. Software must restart the counter before it reaches a programmed limit. If it fails to, the block raises a one-cycle reset request. A restart is not a single write: it is an ordered pair of 16-bit key words sent to the command location. A second ordered pair of keys grants a short, time-limited opportunity to change the configuration once the configuration has been declared updatable.

The block also supports a windowed mode. When the window value is nonzero, a restart that completes while the count is still below that value counts as a fault. A malformed key pair is treated as a fault as well. Each fault produces the same reset request, but only while the watchdog is enabled. Reading the command location returns the live count, and reading the other locations returns the stored settings.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the control word reads 0x080: enable (bit 7) is set, and update-allowed (bit 5) and wide-command (bit 8) are clear. The timeout reads 0x400, the window reads 0, the count reads 0, and the reset request is low.
- R2: Location 0x0 is control, 0x4 is command (a read returns the count), 0x8 is timeout and 0xC is window. Bits above the low 16 of timeout and window are dropped.
- R3: While update-allowed is clear, writes to control, timeout and window take effect at once with no key sequence.
- R4: A key pair for unlocking (0xC520 then 0xD928 in the low 16 bits of consecutive command writes) has no effect while update-allowed is clear. A configuration write made later, after update-allowed has been set, is still rejected.
- R5: While update-allowed is set and no unlock is open, writes to control, timeout and window are ignored.
- R6: After an unlock pair while update-allowed is set, configuration writes are accepted on the 128 clock edges that follow the second key. From then on they are rejected.
- R7: A refresh pair (0xA602 then 0xB480 on consecutive command writes) returns the count to 0 on the second key's edge.
- R8: While enabled, the count rises by one per clock. While disabled, it is held at 0. Writing control with 0x120 disables the watchdog and sets update-allowed.
- R9: When the count equals the timeout while enabled, the reset request is high for exactly the next cycle and the count restarts from 0.
- R10: A first key followed by any command word other than its partner raises the reset request for one cycle after that write, provided the watchdog is enabled. When disabled, no request is raised.
- R11: With a nonzero window, a refresh pair that completes while the count is below the window raises the reset request for one cycle. A refresh at or above the window does not.
- R12: A command word that is not a first key, written when no sequence is pending, changes nothing. A following refresh pair still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 4 | Register location |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
A faulty key-sequence state shows up on the very next command write. Either the count fails to return to zero on readback, or a spurious or missing reset-request pulse appears in the cycle after the second key. A faulty lock state shows up as a configuration readback that differs from the value written, or that changes when it should not. The unlock window is probed exactly at its last accepted edge and its first rejected edge. A counter fault shows up as a wrong readback count a few cycles after a refresh, or as a request pulse one cycle early or late relative to the timeout.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int KEY_W  = 16;

  localparam logic [ADDR_W-1:0] LOC_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] LOC_CMD  = 4'h4;
  localparam logic [ADDR_W-1:0] LOC_TMO  = 4'h8;
  localparam logic [ADDR_W-1:0] LOC_WIN  = 4'hC;

  localparam logic [KEY_W-1:0] KEY_OPEN_A = 16'hC520;
  localparam logic [KEY_W-1:0] KEY_OPEN_B = 16'hD928;
  localparam logic [KEY_W-1:0] KEY_KICK_A = 16'hA602;
  localparam logic [KEY_W-1:0] KEY_KICK_B = 16'hB480;

  localparam int BIT_UPD   = 5;
  localparam int BIT_EN    = 7;
  localparam int BIT_WIDE  = 8;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_OPEN = 2'd1,
    KS_KICK = 2'd2
  } kseq_e;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             unlock_o,
  output logic             refresh_o,
  output logic             err_o
);
  kseq_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    unlock_o  = 1'b0;
    refresh_o = 1'b0;
    err_o     = 1'b0;
    if (cmd_wr_i) begin
      unique case (state_q)
        KS_IDLE: begin
          if (key_i == KEY_OPEN_A)      state_d = KS_OPEN;
          else if (key_i == KEY_KICK_A) state_d = KS_KICK;
        end
        KS_OPEN: begin
          state_d = KS_IDLE;
          if (key_i == KEY_OPEN_B) unlock_o = 1'b1;
          else                     err_o    = 1'b1;
        end
        KS_KICK: begin
          state_d = KS_IDLE;
          if (key_i == KEY_KICK_B) refresh_o = 1'b1;
          else                     err_o     = 1'b1;
        end
        default: state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/kwdt_cfg.sv
module kwdt_cfg
  import kwdt_pkg::*;
#(
  parameter int                TMO_W         = 16,
  parameter int                UNLOCK_CYCLES = 128,
  parameter logic [TMO_W-1:0]  TMO_RST       = 16'h0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TMO_W-1:0]  wdata_i,
  input  logic              unlock_i,
  output logic              en_o,
  output logic              upd_o,
  output logic              wide_o,
  output logic [TMO_W-1:0]  tmo_o,
  output logic [TMO_W-1:0]  win_o,
  output logic              open_o
);
  localparam int UW = $clog2(UNLOCK_CYCLES + 1);
  localparam logic [UW-1:0] UNL_LOAD = UW'(UNLOCK_CYCLES);

  logic             en_q, upd_q, wide_q;
  logic [TMO_W-1:0] tmo_q, win_q;
  logic [UW-1:0]    unl_q, unl_d;
  logic             cfg_ok, ctrl_we, tmo_we, win_we, unl_we;

  assign open_o  = (unl_q != '0);
  assign cfg_ok  = !upd_q || open_o;
  assign ctrl_we = wr_i && cfg_ok && (addr_i == LOC_CTRL);
  assign tmo_we  = wr_i && cfg_ok && (addr_i == LOC_TMO);
  assign win_we  = wr_i && cfg_ok && (addr_i == LOC_WIN);

  always_comb begin
    unl_we = 1'b0;
    unl_d  = unl_q;
    if (unlock_i && upd_q) begin
      unl_we = 1'b1;
      unl_d  = UNL_LOAD;
    end else if (open_o) begin
      unl_we = 1'b1;
      unl_d  = unl_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      upd_q  <= 1'b0;
      wide_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q   <= wdata_i[BIT_EN];
      upd_q  <= wdata_i[BIT_UPD];
      wide_q <= wdata_i[BIT_WIDE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmo_q <= TMO_RST;
    else if (tmo_we) tmo_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (win_we) win_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     unl_q <= '0;
    else if (unl_we) unl_q <= unl_d;
  end

  assign en_o   = en_q;
  assign upd_o  = upd_q;
  assign wide_o = wide_q;
  assign tmo_o  = tmo_q;
  assign win_o  = win_q;
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic [TMO_W-1:0] win_i,
  input  logic             refresh_i,
  input  logic             key_err_i,
  output logic [TMO_W-1:0] cnt_o,
  output logic             req_o
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             hit, early;

  assign hit   = en_i && (cnt_q == tmo_i);
  assign early = refresh_i && (win_i != '0) && (cnt_q < win_i);

  always_comb begin
    if (!en_i || refresh_i || hit) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
    req_d = en_i && (hit || early || key_err_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int               TMO_W         = 16,
  parameter int               UNLOCK_CYCLES = 128,
  parameter logic [TMO_W-1:0] TMO_RST       = 16'h0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic             cmd_wr, unlock, refresh, key_err;
  logic             en, upd, wide, unl_open;
  logic [TMO_W-1:0] tmo, win, cnt;
  logic             unused_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign cmd_wr    = wr_en_i && (addr_i == LOC_CMD);
  assign unused_hi = ^wdata_i[DATA_W-1:KEY_W];

  kwdt_keyseq u_keyseq (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .cmd_wr_i  (cmd_wr),
    .key_i     (wdata_i[KEY_W-1:0]),
    .unlock_o  (unlock),
    .refresh_o (refresh),
    .err_o     (key_err)
  );

  kwdt_cfg #(
    .TMO_W         (TMO_W),
    .UNLOCK_CYCLES (UNLOCK_CYCLES),
    .TMO_RST       (TMO_RST)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .wr_i     (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i[TMO_W-1:0]),
    .unlock_i (unlock),
    .en_o     (en),
    .upd_o    (upd),
    .wide_o   (wide),
    .tmo_o    (tmo),
    .win_o    (win),
    .open_o   (unl_open)
  );

  kwdt_counter #(.TMO_W(TMO_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .en_i      (en),
    .tmo_i     (tmo),
    .win_i     (win),
    .refresh_i (refresh),
    .key_err_i (key_err),
    .cnt_o     (cnt),
    .req_o     (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      LOC_CTRL: begin
        rdata_o[BIT_EN]   = en;
        rdata_o[BIT_UPD]  = upd;
        rdata_o[BIT_WIDE] = wide;
      end
      LOC_CMD: rdata_o = DATA_W'(cnt);
      LOC_TMO: rdata_o = DATA_W'(tmo);
      LOC_WIN: rdata_o = DATA_W'(win);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              en_i,
  input logic              upd_i,
  input logic              open_i,
  input logic              unlock_i,
  input logic              refresh_i,
  input logic [TMO_W-1:0]  tmo_i,
  input logic [TMO_W-1:0]  cnt_i,
  input logic              req_i
);
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0)); // R8

  AST_TMO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i == tmo_i) |=> req_i); // R9

  AST_LOCKED_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !open_i && wr_en_i && addr_i == LOC_TMO) |=> $stable(tmo_i)); // R5

  AST_REFRESH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (cnt_i == '0)); // R7

  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_i); // R10

  AST_UNLOCK_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && unlock_i && !open_i) |=> !open_i); // R4
endmodule

bind kwdt_top kwdt_chk #(.TMO_W(TMO_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_int_n),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .en_i      (en),
  .upd_i     (upd),
  .open_i    (unl_open),
  .unlock_i  (unlock),
  .refresh_i (refresh),
  .tmo_i     (tmo),
  .cnt_i     (cnt),
  .req_i     (rst_req_o)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_IDLE = 2'd2;

  // {op, addr, data, expected, requirement}
  localparam int NV = 19;
  localparam logic [73:0] VECS [NV] = '{
    {OP_WR,   4'h0, 32'h0000_0000, 32'h0, 4'd3},  // R3 disable directly
    {OP_RD,   4'h0, 32'h0,         32'h0, 4'd3},  // R3
    {OP_WR,   4'h8, 32'hFFFF_0123, 32'h0, 4'd3},  // R3 / R2 upper bits dropped
    {OP_RD,   4'h8, 32'h0,         32'h0000_0123, 4'd2},  // R2
    {OP_WR,   4'h4, 32'h0000_C520, 32'h0, 4'd4},  // R4 unlock while update clear
    {OP_WR,   4'h4, 32'h0000_D928, 32'h0, 4'd4},
    {OP_WR,   4'h0, 32'h0000_0120, 32'h0, 4'd8},  // R8 0x120
    {OP_RD,   4'h0, 32'h0,         32'h0000_0120, 4'd8},
    {OP_WR,   4'h8, 32'h0000_0055, 32'h0, 4'd4},
    {OP_RD,   4'h8, 32'h0,         32'h0000_0123, 4'd4},  // R4 rejected
    {OP_WR,   4'hC, 32'h0000_0007, 32'h0, 4'd5},
    {OP_RD,   4'hC, 32'h0,         32'h0, 4'd5},  // R5 rejected
    {OP_WR,   4'h4, 32'h0000_C520, 32'h0, 4'd6},
    {OP_WR,   4'h4, 32'h0000_D928, 32'h0, 4'd6},
    {OP_WR,   4'h8, 32'h0000_0040, 32'h0, 4'd6},
    {OP_RD,   4'h8, 32'h0,         32'h0000_0040, 4'd6},  // R6 accepted
    {OP_IDLE, 4'h0, 32'd130,       32'h0, 4'd6},
    {OP_WR,   4'h8, 32'h0000_0099, 32'h0, 4'd6},
    {OP_RD,   4'h8, 32'h0,         32'h0000_0040, 4'd6}   // R6 closed
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [3:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  kwdt_top dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .rst_req_o (rst_req_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !done) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: act=%0d cycles exp<%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic unlock();
    wr(4'h4, 32'h0000_C520);
    wr(4'h4, 32'h0000_D928);
  endtask

  task automatic kick();
    wr(4'h4, 32'h0000_A602);
    wr(4'h4, 32'h0000_B480);
  endtask

  initial begin
    logic [31:0] v;
    rst_ni = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 reset state
    rd(4'h0, v); check("R1 ctrl", v, 32'h080);
    rd(4'h8, v); check("R1 timeout", v, 32'h400);
    rd(4'hC, v); check("R1 window", v, 32'h0);
    rd(4'h4, v); check("R1 count", v, 32'h0);
    check("R1 req", {31'b0, rst_req_o}, 32'h0);
    @(negedge clk_i);
    rd(4'h4, v); check("R8 count step", v, 32'h1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  a, rq;
      logic [31:0] d, e;
      {op, a, d, e, rq} = VECS[i];
      if (op == OP_WR) wr(a, d);
      else if (op == OP_RD) begin
        rd(a, v);
        check($sformatf("R%0d vector %0d", rq, i), v, e);
      end else repeat (d) @(negedge clk_i);
    end

    // R6 last accepted edge and first rejected edge
    unlock();
    repeat (127) @(negedge clk_i);
    wr(4'hC, 32'h0000_0003);
    rd(4'hC, v); check("R6 edge 128", v, 32'h3);
    unlock();
    repeat (128) @(negedge clk_i);
    wr(4'hC, 32'h0000_0005);
    rd(4'hC, v); check("R6 edge 129", v, 32'h3);

    // timeout, refresh and counting
    unlock();
    wr(4'hC, 32'h0);
    wr(4'h8, 32'h0000_0010);
    wr(4'h0, 32'h0000_00A0);
    kick();
    rd(4'h4, v); check("R7 count cleared", v, 32'h0);
    repeat (5) @(negedge clk_i);
    rd(4'h4, v); check("R8 count rises", v, 32'h5);
    repeat (11) @(negedge clk_i);
    check("R9 no early req", {31'b0, rst_req_o}, 32'h0);
    @(negedge clk_i);
    check("R9 req pulse", {31'b0, rst_req_o}, 32'h1);
    rd(4'h4, v); check("R9 count wraps", v, 32'h0);
    @(negedge clk_i);
    check("R9 pulse one cycle", {31'b0, rst_req_o}, 32'h0);

    // R10 key faults
    kick();
    wr(4'h4, 32'h0000_A602);
    wr(4'h4, 32'h0000_0000);
    check("R10 wrong second key", {31'b0, rst_req_o}, 32'h1);
    @(negedge clk_i);
    check("R10 single cycle", {31'b0, rst_req_o}, 32'h0);
    wr(4'h4, 32'h0000_C520);
    wr(4'h4, 32'h0000_A602);
    check("R10 partner missing", {31'b0, rst_req_o}, 32'h1);

    // R12 stray command word
    kick();
    wr(4'h4, 32'h0000_1234);
    check("R12 no req", {31'b0, rst_req_o}, 32'h0);
    kick();
    check("R12 refresh still works", {31'b0, rst_req_o}, 32'h0);
    rd(4'h4, v); check("R12 count cleared", v, 32'h0);

    // R11 windowed refresh
    unlock();
    wr(4'hC, 32'h0000_0008);
    kick();
    check("R11 early refresh", {31'b0, rst_req_o}, 32'h1);
    repeat (8) @(negedge clk_i);
    kick();
    check("R11 refresh in window", {31'b0, rst_req_o}, 32'h0);
    rd(4'h4, v); check("R11 count cleared", v, 32'h0);

    // R10 / R8 disabled
    unlock();
    wr(4'h0, 32'h0000_0020);
    rd(4'h0, v); check("R8 ctrl disabled", v, 32'h020);
    wr(4'h4, 32'h0000_A602);
    wr(4'h4, 32'h0000_0000);
    check("R10 quiet when disabled", {31'b0, rst_req_o}, 32'h0);
    repeat (3) @(negedge clk_i);
    rd(4'h4, v); check("R8 held at zero", v, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule